// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps a free-running master count that advances at a fixed effective rate, whatever the frequency of the reference clock that drives it. On every reference clock cycle an accumulator gains a programmable numerator. Each time the accumulator reaches the programmed denominator, the denominator is taken back off and the count steps by one. The count rate is therefore the reference rate times numerator over denominator. With a 38.4 MHz reference and the reset ratio 4/25, this gives 6.144 MHz. A 19.2 MHz reference uses 8/25 and a 12 MHz reference uses 64/125. Ratios that are not whole numbers are handled with no drift over time.

Software sets the ratio through a small register port. Each ratio register is 32 bits wide. Only the low 12 bits form the fraction, and the upper 20 bits are kept exactly as written. When the reference clock changes, software writes the new ratio and the count keeps its value. The full count is available on a parallel output. It can also be read over the port as two halves. Reading the low half captures the high half at the same instant, so a low-then-high read sequence always returns one coherent value.

Top module: `rtc_frac_counter`

## Requirements
- R1: After reset the count is zero, the numerator register reads 0x00000004 and the denominator register reads 0x00000019.
- R2: Register map: 0x00 is the low count half, 0x04 is the captured high count half, 0x10 is the numerator and 0x14 is the denominator. Read data and reg_rvalid appear in the cycle after the reg_rd strobe. Other addresses read as zero, and writes to them change nothing.
- R3: While numerator < denominator, the count advances by exactly floor(N*num/den) in the N cycles that follow a denominator write.
- R4: When the numerator is greater than or equal to the denominator, including a denominator of zero, the count advances on every cycle.
- R5: The fraction is taken from bits 11:0 of each ratio register. Bits 31:12 are stored and read back unchanged, and they have no effect on the rate.
- R6: The accumulation step on the clock edge that writes a new numerator still uses the old numerator. A numerator write does not clear the accumulator.
- R7: A denominator write clears the accumulator, and the count does not advance on that edge.
- R8: Reading the low half captures the high half in the same cycle. A later read of the high half returns that captured value, even if the count has moved on since.
- R9: The count never advances by more than one per cycle and never goes backwards, except when it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | One-cycle pulse after a read strobe (no back-pressure) |
| count_o | output | COUNT_W | Live master count |

## Verification
The bench times ratio changes that land on the edge of an accumulation step. If a design applies a new numerator one edge too early, or clears the accumulator on a numerator write, the count shifts by one tick at a known cycle, and the bench catches that shift. A design that forgot to clear the accumulator on a denominator write would give an extra tick on that edge. Ratios of one or more, including a zero denominator, catch accumulators that overflow or stall. Reading the halves around a carry out of the low half catches a high half that is not captured at the moment the low half is read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_NUM    = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_DEN    = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_NUM,
    SEL_DEN
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_CNT_LO: return SEL_CNT_LO;
      ADDR_CNT_HI: return SEL_CNT_HI;
      ADDR_NUM:    return SEL_NUM;
      ADDR_DEN:    return SEL_DEN;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int FRAC_W  = 12,
  parameter int NUM_RST = 4,
  parameter int DEN_RST = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  num_reg,
  output logic [REG_W-1:0]  den_reg,
  output logic [FRAC_W-1:0] num_frac,
  output logic [FRAC_W-1:0] den_frac,
  output logic              den_load
);
  reg_sel_e sel;

  always_comb sel = decode_addr(addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_reg <= REG_W'(NUM_RST);
      den_reg <= REG_W'(DEN_RST);
    end else if (wr_en) begin
      if (sel == SEL_NUM) num_reg <= wdata;
      if (sel == SEL_DEN) den_reg <= wdata;
    end
  end

  // the fraction is the low field; upper bits are storage only
  always_comb begin
    num_frac = num_reg[FRAC_W-1:0];
    den_frac = den_reg[FRAC_W-1:0];
    den_load = wr_en && (sel == SEL_DEN);
  end
endmodule

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  input  logic              clear,
  output logic              tick,
  output logic [FRAC_W-1:0] level
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;
  logic              saturate;
  logic              reach;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, num};
    saturate = (num >= den);
    reach    = (sum >= {1'b0, den});
    tick     = !clear && (saturate || reach);
    level    = acc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear) begin
      acc_q <= '0;
    end else if (saturate) begin
      acc_q <= '0;
    end else if (reach) begin
      acc_q <= FRAC_W'(sum - {1'b0, den});
    end else begin
      acc_q <= FRAC_W'(sum);
    end
  end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int COUNT_W = 64,
  localparam int HALF_W = COUNT_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               capture,
  output logic [COUNT_W-1:0] count,
  output logic [HALF_W-1:0]  hi_held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_held <= '0;
    end else if (capture) begin
      hi_held <= count[COUNT_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter
  import rtc_pkg::*;
#(
  parameter int COUNT_W = 64,
  parameter int REG_W   = 32,
  parameter int FRAC_W  = 12,
  parameter int NUM_RST = 4,
  parameter int DEN_RST = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               reg_rvalid,
  output logic [COUNT_W-1:0] count_o
);
  localparam int HALF_W = COUNT_W / 2;

  logic [REG_W-1:0]  num_reg;
  logic [REG_W-1:0]  den_reg;
  logic [FRAC_W-1:0] num_frac;
  logic [FRAC_W-1:0] den_frac;
  logic              den_load;
  logic              tick;
  logic [FRAC_W-1:0] acc_level;
  logic [HALF_W-1:0] hi_latch;
  logic              lo_read;
  reg_sel_e          rd_sel;
  logic [REG_W-1:0]  rd_mux;

  rtc_cfg_regs #(
    .REG_W(REG_W), .FRAC_W(FRAC_W), .NUM_RST(NUM_RST), .DEN_RST(DEN_RST)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .num_reg(num_reg), .den_reg(den_reg),
    .num_frac(num_frac), .den_frac(den_frac), .den_load(den_load)
  );

  rtc_frac_accum #(.FRAC_W(FRAC_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .num(num_frac), .den(den_frac),
    .clear(den_load), .tick(tick), .level(acc_level)
  );

  rtc_count_core #(.COUNT_W(COUNT_W)) i_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .capture(lo_read),
    .count(count_o), .hi_held(hi_latch)
  );

  always_comb begin
    rd_sel  = decode_addr(reg_addr);
    lo_read = reg_rd && (rd_sel == SEL_CNT_LO);
    rd_mux  = '0;
    case (rd_sel)
      SEL_CNT_LO: rd_mux[HALF_W-1:0] = count_o[HALF_W-1:0];
      SEL_CNT_HI: rd_mux[HALF_W-1:0] = hi_latch;
      SEL_NUM:    rd_mux = num_reg;
      SEL_DEN:    rd_mux = den_reg;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_frac_counter_chk.sv
module rtc_frac_counter_chk
  import rtc_pkg::*;
#(
  parameter int COUNT_W = 64,
  parameter int FRAC_W  = 12,
  localparam int HALF_W = COUNT_W / 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_rvalid,
  input logic [COUNT_W-1:0] count_o,
  input logic [FRAC_W-1:0]  num_frac,
  input logic [FRAC_W-1:0]  den_frac,
  input logic               den_load,
  input logic [FRAC_W-1:0]  acc_level,
  input logic [HALF_W-1:0]  hi_latch
);
  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

  assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (den_frac != '0) |-> (acc_level < den_frac));

  assert_full_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (num_frac >= den_frac && !den_load) |=> count_o == $past(count_o) + 1'b1);

  assert_den_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DEN) |=> $stable(count_o));

  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_rvalid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  assert_hi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == ADDR_CNT_LO) |=> $stable(hi_latch));
endmodule

bind rtc_frac_counter rtc_frac_counter_chk #(.COUNT_W(COUNT_W), .FRAC_W(FRAC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .count_o(count_o),
  .num_frac(num_frac), .den_frac(den_frac), .den_load(den_load),
  .acc_level(acc_level), .hi_latch(hi_latch)
);

// File: tb/test_rtc_frac_counter.sv
module test_rtc_frac_counter;
  localparam int CW = 24;
  localparam int HW = CW / 2;
  localparam int NV = 9;
  localparam int VEC_NUM [NV] = '{4, 8, 64, 3, 1,    0,  25, 30, 7};
  localparam int VEC_DEN [NV] = '{25, 25, 125, 7, 4095, 25, 25, 25, 0};
  localparam int VEC_CYC [NV] = '{250, 100, 1000, 20, 5000, 50, 10, 12, 9};
  localparam int VEC_EXP [NV] = '{40, 32, 512, 8, 1,    0,  10, 12, 9};

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_wr = 0;
  logic          reg_rd = 0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_rvalid;
  logic [CW-1:0] count_o;

  int errors = 0;
  int checks = 0;
  logic [31:0]   rd_val;
  logic          rd_vld;
  logic [CW-1:0] snap;
  logic [CW-1:0] c0;

  always #5 clk = ~clk;

  rtc_frac_counter #(.COUNT_W(CW)) i_rtc_frac_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .count_o(count_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    reg_rd = 1; reg_addr = a; snap = count_o;
    @(posedge clk); #1;
    reg_rd = 0; rd_val = reg_rdata; rd_vld = reg_rvalid;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    check("R1 count", count_o, 0);
    rd(8'h10); check("R1 num", rd_val, 32'h4); check("R2 rvalid", rd_vld, 1);
    rd(8'h14); check("R1 den", rd_val, 32'h19);
    #10 check("R2 rvalid drop", reg_rvalid, 0);

    // vector table: R3 for ratios below one, R4 for ratio >= 1
    for (int i = 0; i < NV; i++) begin
      wr(8'h10, VEC_NUM[i]);
      wr(8'h14, VEC_DEN[i]);
      c0 = count_o;
      step(VEC_CYC[i]);
      check(VEC_NUM[i] >= VEC_DEN[i] ? "R4 rate" : "R3 rate",
            CW'(count_o - c0), VEC_EXP[i]);
    end

    // R5 upper bits kept, no effect on rate
    wr(8'h10, 32'hABCDE003);
    wr(8'h14, 32'h1234500A);
    c0 = count_o;
    step(100);
    check("R5 rate", CW'(count_o - c0), 30);
    rd(8'h10); check("R5 num readback", rd_val, 32'hABCDE003);
    rd(8'h14); check("R5 den readback", rd_val, 32'h1234500A);

    // R2 unmapped address
    wr(8'h08, 32'hFFFFFFFF);
    rd(8'h08); check("R2 unmapped read", rd_val, 0);
    rd(8'h10); check("R2 num untouched", rd_val, 32'hABCDE003);
    rd(8'h14); check("R2 den untouched", rd_val, 32'h1234500A);

    // R6 numerator change: old value used on the write edge, acc kept
    wr(8'h10, 3);
    wr(8'h14, 10);
    c0 = count_o;
    step(1);
    wr(8'h10, 7);
    check("R6 write edge", CW'(count_o - c0), 0);
    step(1);
    check("R6 acc kept", CW'(count_o - c0), 1);

    // R7 denominator write clears acc, no tick on that edge
    wr(8'h10, 5);
    wr(8'h14, 10);
    c0 = count_o;
    step(1);
    wr(8'h14, 10);
    check("R7 no tick", CW'(count_o - c0), 0);
    step(2);
    check("R7 restart", CW'(count_o - c0), 1);

    // R8 coherent halves
    wr(8'h10, 1);
    wr(8'h14, 1);
    rd(8'h00);
    c0 = snap;
    check("R8 low half", rd_val, {20'd0, c0[HW-1:0]});
    step(5000);
    rd(8'h04);
    check("R8 held high", rd_val, {20'd0, c0[CW-1:HW]});
    // R9 full rate still one per cycle
    c0 = count_o;
    step(7);
    check("R9 one per cycle", CW'(count_o - c0), 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule